// File: doc/BRIEF.md
# Gradient-Descent Channel-Estimate Refiner

This block improves a complex channel-estimate matrix by one gradient-descent step each time it is started. Because it moves toward the least-squares solution a step at a time, no matrix has to be inverted. The estimate has M rows and N columns, and each entry has a signed 8-bit real part and a signed 8-bit imaginary part. On each step the block subtracts a scaled residual from every entry. The residual is the product of a real M×M correlation matrix with the estimate, minus a complex M×N correlation matrix. The step size is a power of two below one, applied as an arithmetic right shift.

Both correlation matrices stay outside the block and are read through combinational read ports: the address goes out and the data comes back in the same cycle. The block holds the estimate itself, in two banks. One bank is readable and the other is written during a sweep, so every entry of a sweep is computed from the values that were in place before the sweep began. The new values become visible all at once when the sweep finishes. A single complex multiply-accumulate path is shared by all entries, and a row counter, a column counter and an inner counter sequence it. Software loads the starting estimate through a write port while the block is idle, and the detector reads the result through a read port.

Top module: `gd_update`

## Requirements
- R1: After reset, `busy` and `done` are low and every estimate entry reads back as zero in both parts.
- R2: While idle, a write with `ld_en` high stores (`ld_re`, `ld_im`) at the entry whose row-major index is `ld_addr` = row·N + col. The value can be read at `rd_addr` from the next cycle on.
- R3: For each entry (i,j) a sweep forms the residual sum over k of C(i,k)·E(k,j) − X(i,j). The real and imaginary parts are formed separately in wide accumulators. C is read at `rbb_addr` = i·M + k and X at `rbr_addr` = i·N + j. E is the estimate as it stood before the sweep began.
- R4: The residual is shifted right arithmetically by `shift` (0 to 15), rounding toward minus infinity. The shift amount is captured on the cycle `start` is accepted.
- R5: The new entry is the old entry minus the shifted residual, clamped to the range −128 to 127, in each part separately.
- R6: `start` is accepted only while idle. `done` is high for exactly one cycle, M·N·(M+1) clock edges after the edge that accepted `start`. `busy` is high from the accepting edge until the edge that raises `done`.
- R7: While `busy` is high, `start` pulses and `ld_en` writes have no effect on the sweep's timing or on any stored value.
- R8: While a sweep runs, `rd_addr` returns the values from before the sweep. All updated values appear together in the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one sweep (accepted while idle) |
| shift | input | 4 | Step size as a right-shift amount |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle end-of-sweep pulse |
| rbb_addr | output | clog2(M·M) | Real correlation read address, row-major |
| rbb_data | input | 8 | Real correlation entry, signed |
| rbr_addr | output | clog2(M·N) | Complex correlation read address, row-major |
| rbr_re | input | 8 | Complex correlation real part, signed |
| rbr_im | input | 8 | Complex correlation imaginary part, signed |
| ld_en | input | 1 | Estimate load strobe |
| ld_addr | input | clog2(M·N) | Estimate load index, row-major |
| ld_re | input | 8 | Load value, real part |
| ld_im | input | 8 | Load value, imaginary part |
| rd_addr | input | clog2(M·N) | Estimate read index, row-major |
| rd_re | output | 8 | Estimate read, real part |
| rd_im | output | 8 | Estimate read, imaginary part |

## Verification
A wrong counter value or a stale accumulator corrupts whole rows or columns of the estimate. That damage only shows at the read port once `done` rises, so the bench compares every entry after every sweep. It also chains sweeps, so that an error which feeds into the next step grows instead of hiding. A bank-select error shows up earlier, as changed values during a sweep, so the bench probes the read port while `busy` is high. A sequencing error shifts the `done` pulse and is caught as a cycle-count mismatch in the same sweep.

// File: rtl/gdu_pkg.sv
package gdu_pkg;

    localparam int ACC_W = 24;

    typedef struct packed {
        logic signed [7:0] re;
        logic signed [7:0] im;
    } cpx8_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_UPD  = 2'd2
    } gdu_state_t;

    function automatic logic signed [7:0] clamp8(input logic signed [31:0] v);
        if (v > 32'sd127)  return 8'sd127;
        if (v < -32'sd128) return -8'sd128;
        return v[7:0];
    endfunction

    // one part of one entry: old - ((acc - corr) >>> sh), clamped
    function automatic logic signed [7:0] step_part(
        input logic signed [7:0]       old_v,
        input logic signed [ACC_W-1:0] acc,
        input logic signed [7:0]       corr,
        input logic [3:0]              sh
    );
        logic signed [31:0] res;
        logic signed [31:0] dlt;
        logic signed [31:0] nv;
        res = acc;
        res = res - corr;
        dlt = res >>> sh;
        nv  = old_v;
        nv  = nv - dlt;
        return clamp8(nv);
    endfunction

endpackage

// File: rtl/gdu_seq.sv
module gdu_seq
    import gdu_pkg::*;
#(
    parameter int M = 4,
    parameter int N = 4,
    localparam int RW = (M > 1) ? $clog2(M) : 1,
    localparam int CW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [3:0]    shift,
    output logic          busy,
    output logic          done,
    output logic          acc_en,
    output logic          acc_first,
    output logic          upd_en,
    output logic          flip,
    output logic [RW-1:0] row,
    output logic [CW-1:0] col,
    output logic [RW-1:0] kk,
    output logic [3:0]    sh_q
);
    gdu_state_t st;
    logic last_entry;

    assign last_entry = (row == RW'(M - 1)) && (col == CW'(N - 1));
    assign busy      = (st != ST_IDLE);
    assign acc_en    = (st == ST_ACC);
    assign acc_first = acc_en && (kk == '0);
    assign upd_en    = (st == ST_UPD);
    assign flip      = upd_en && last_entry;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            row  <= '0;
            col  <= '0;
            kk   <= '0;
            sh_q <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        st   <= ST_ACC;
                        row  <= '0;
                        col  <= '0;
                        kk   <= '0;
                        sh_q <= shift;
                    end
                end
                ST_ACC: begin
                    if (kk == RW'(M - 1)) begin
                        kk <= '0;
                        st <= ST_UPD;
                    end else begin
                        kk <= kk + 1'b1;
                    end
                end
                ST_UPD: begin
                    if (last_entry) begin
                        st   <= ST_IDLE;
                        row  <= '0;
                        col  <= '0;
                        done <= 1'b1;
                    end else begin
                        st <= ST_ACC;
                        if (col == CW'(N - 1)) begin
                            col <= '0;
                            row <= row + 1'b1;
                        end else begin
                            col <= col + 1'b1;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r7_start_only_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));
    a_r6_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

endmodule

// File: rtl/gdu_mac.sv
module gdu_mac
    import gdu_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    first,
    input  logic                    clr,
    input  logic signed [7:0]       w,
    input  cpx8_t                   x,
    output logic signed [ACC_W-1:0] acc_re,
    output logic signed [ACC_W-1:0] acc_im
);
    logic signed [15:0] p_re;
    logic signed [15:0] p_im;

    assign p_re = w * x.re;
    assign p_im = w * x.im;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_re <= '0;
            acc_im <= '0;
        end else if (en) begin
            acc_re <= acc_re + {{(ACC_W-16){p_re[15]}}, p_re};
            acc_im <= acc_im + {{(ACC_W-16){p_im[15]}}, p_im};
        end
    end

    // R3: every entry starts its sum from a cleared accumulator
    a_r3_acc_fresh: assert property (@(posedge clk) disable iff (rst)
        first |-> (acc_re == '0 && acc_im == '0));

endmodule

// File: rtl/gdu_abank.sv
module gdu_abank
    import gdu_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  cpx8_t         ld_val,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  cpx8_t         wr_val,
    input  logic          flip,
    input  logic [AW-1:0] ra0,
    output cpx8_t         rd0,
    input  logic [AW-1:0] ra1,
    output cpx8_t         rd1,
    input  logic [AW-1:0] ra2,
    output cpx8_t         rd2,
    output logic          cur
);
    cpx8_t mem [0:1][0:DEPTH-1];

    assign rd0 = mem[cur][ra0];
    assign rd1 = mem[cur][ra1];
    assign rd2 = mem[cur][ra2];

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= 1'b0;
            for (int b = 0; b < 2; b++) begin
                for (int e = 0; e < DEPTH; e++) begin
                    mem[b][e] <= '0;
                end
            end
        end else begin
            if (ld_en)
                mem[cur][ld_addr] <= ld_val;
            if (wr_en)
                mem[~cur][wr_addr] <= wr_val;
            if (flip)
                cur <= ~cur;
        end
    end

    // R8: the readable bank is never the target of sweep writes
    a_r8_read_bank_stable: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !ld_en && !flip) |=> $stable(cur));

endmodule

// File: rtl/gd_update.sv
module gd_update
    import gdu_pkg::*;
#(
    parameter int M = 4,
    parameter int N = 4,
    localparam int DEPTH = M * N,
    localparam int CAW = (M * M > 1) ? $clog2(M * M) : 1,
    localparam int EAW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int RW  = (M > 1) ? $clog2(M) : 1,
    localparam int CW  = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [3:0]        shift,
    output logic              busy,
    output logic              done,
    output logic [CAW-1:0]    rbb_addr,
    input  logic signed [7:0] rbb_data,
    output logic [EAW-1:0]    rbr_addr,
    input  logic signed [7:0] rbr_re,
    input  logic signed [7:0] rbr_im,
    input  logic              ld_en,
    input  logic [EAW-1:0]    ld_addr,
    input  logic signed [7:0] ld_re,
    input  logic signed [7:0] ld_im,
    input  logic [EAW-1:0]    rd_addr,
    output logic signed [7:0] rd_re,
    output logic signed [7:0] rd_im
);
    logic          acc_en, acc_first, upd_en, flip, cur;
    logic [RW-1:0] row, kk;
    logic [CW-1:0] col;
    logic [3:0]    sh_q;
    logic [EAW-1:0] a_k_addr, a_ij_addr;
    cpx8_t a_ext, a_k, a_ij, new_val, ld_val;
    logic signed [ACC_W-1:0] acc_re, acc_im;

    gdu_seq #(.M(M), .N(N)) u_seq (
        .clk(clk), .rst(rst), .start(start), .shift(shift),
        .busy(busy), .done(done), .acc_en(acc_en), .acc_first(acc_first),
        .upd_en(upd_en), .flip(flip), .row(row), .col(col), .kk(kk),
        .sh_q(sh_q)
    );

    assign rbb_addr  = CAW'(int'(row) * M + int'(kk));
    assign a_k_addr  = EAW'(int'(kk) * N + int'(col));
    assign a_ij_addr = EAW'(int'(row) * N + int'(col));
    assign rbr_addr  = a_ij_addr;

    gdu_mac u_mac (
        .clk(clk), .rst(rst), .en(acc_en), .first(acc_first), .clr(upd_en),
        .w(rbb_data), .x(a_k), .acc_re(acc_re), .acc_im(acc_im)
    );

    always_comb begin
        new_val.re = step_part(a_ij.re, acc_re, rbr_re, sh_q);
        new_val.im = step_part(a_ij.im, acc_im, rbr_im, sh_q);
    end

    assign ld_val = '{re: ld_re, im: ld_im};

    gdu_abank #(.DEPTH(DEPTH)) u_bank (
        .clk(clk), .rst(rst),
        .ld_en(ld_en && !busy), .ld_addr(ld_addr), .ld_val(ld_val),
        .wr_en(upd_en), .wr_addr(a_ij_addr), .wr_val(new_val),
        .flip(flip),
        .ra0(rd_addr), .rd0(a_ext),
        .ra1(a_k_addr), .rd1(a_k),
        .ra2(a_ij_addr), .rd2(a_ij),
        .cur(cur)
    );

    assign rd_re = a_ext.re;
    assign rd_im = a_ext.im;

    // R8: results become visible exactly when done is raised
    a_r8_swap_on_done: assert property (@(posedge clk) disable iff (rst)
        done |-> (cur != $past(cur)));
    // R7: while busy the visible bank does not change except at the swap
    a_r7_bank_held: assert property (@(posedge clk) disable iff (rst)
        (busy && !flip) |=> $stable(cur));

endmodule

// File: tb/sim_gd_update.sv
`timescale 1ns/1ps
module sim_gd_update;
    localparam int M = 4;
    localparam int N = 4;
    localparam int D = M * N;
    localparam int SWEEP = M * N * (M + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [3:0] shift = '0;
    logic busy, done;
    logic [3:0] rbb_addr;
    logic signed [7:0] rbb_data;
    logic [3:0] rbr_addr;
    logic signed [7:0] rbr_re, rbr_im;
    logic ld_en = 1'b0;
    logic [3:0] ld_addr = '0;
    logic signed [7:0] ld_re = '0, ld_im = '0;
    logic [3:0] rd_addr = '0;
    logic signed [7:0] rd_re, rd_im;

    logic signed [7:0] cm [D];
    logic signed [7:0] xr [D];
    logic signed [7:0] xi [D];
    int er [D];
    int ei [D];

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 0;

    always #2 clk = ~clk;

    assign rbb_data = cm[rbb_addr];
    assign rbr_re   = xr[rbr_addr];
    assign rbr_im   = xi[rbr_addr];

    gd_update #(.M(M), .N(N)) u0 (
        .clk(clk), .rst(rst), .start(start), .shift(shift),
        .busy(busy), .done(done),
        .rbb_addr(rbb_addr), .rbb_data(rbb_data),
        .rbr_addr(rbr_addr), .rbr_re(rbr_re), .rbr_im(rbr_im),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_re(ld_re), .ld_im(ld_im),
        .rd_addr(rd_addr), .rd_re(rd_re), .rd_im(rd_im)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int floor_shift(input int v, input int s);
        int q;
        q = 1 << s;
        if (v >= 0) return v / q;
        return -((-v + q - 1) / q);
    endfunction

    function automatic int clampv(input int v);
        return (v > 127) ? 127 : ((v < -128) ? -128 : v);
    endfunction

    // R3/R4/R5 reference sweep on the bench model
    task automatic model_step(input int s);
        int nr [D];
        int ni [D];
        for (int i = 0; i < M; i++) begin
            for (int j = 0; j < N; j++) begin
                int sr, si;
                sr = 0; si = 0;
                for (int k = 0; k < M; k++) begin
                    sr += int'(cm[i*M+k]) * er[k*N+j];
                    si += int'(cm[i*M+k]) * ei[k*N+j];
                end
                sr -= int'(xr[i*N+j]);
                si -= int'(xi[i*N+j]);
                nr[i*N+j] = clampv(er[i*N+j] - floor_shift(sr, s));
                ni[i*N+j] = clampv(ei[i*N+j] - floor_shift(si, s));
            end
        end
        for (int e = 0; e < D; e++) begin
            er[e] = nr[e];
            ei[e] = ni[e];
        end
    endtask

    task automatic load_est();
        for (int e = 0; e < D; e++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_addr = 4'(e);
            ld_re = 8'(er[e]); ld_im = 8'(ei[e]);
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic compare_all(input string tag);
        for (int e = 0; e < D; e++) begin
            @(negedge clk);
            rd_addr = 4'(e);
            #1;
            check(tag, int'(rd_re), er[e]);
            check(tag, int'(rd_im), ei[e]);
        end
    endtask

    // runs one sweep; if meddle, pulses start and ld_en mid-sweep (R7)
    // and probes the read port for old values (R8)
    task automatic run_sweep(input int s, input bit meddle);
        int cnt;
        int old0r, old0i;
        old0r = er[0]; old0i = ei[0];
        @(negedge clk);
        start = 1'b1; shift = 4'(s);
        @(posedge clk);
        cnt = 0;
        @(negedge clk);
        start = 1'b0;
        shift = 4'(15 - s);
        check("R6 busy after start", int'(busy), 1);
        forever begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (done) break;
            if (cnt > 4 * SWEEP) break;
            if (meddle && cnt == 5) begin
                start = 1'b1;
                ld_en = 1'b1; ld_addr = 4'd0; ld_re = 8'sd77; ld_im = -8'sd77;
            end else if (meddle && cnt == 6) begin
                start = 1'b0; ld_en = 1'b0;
                rd_addr = 4'd0;
                #1;
                check("R8 old value during sweep re", int'(rd_re), old0r);
                check("R8 old value during sweep im", int'(rd_im), old0i);
            end
        end
        check("R6 sweep length", cnt, SWEEP);
        check("R6 busy low at done", int'(busy), 0);
        @(negedge clk);
        check("R6 done one cycle", int'(done), 0);
        check("R7 no restart", int'(busy), 0);
        model_step(s);
    endtask

    task automatic rand_mats(input int lim);
        for (int e = 0; e < D; e++) begin
            cm[e] = 8'($urandom % 256);
            xr[e] = 8'($urandom % 256);
            xi[e] = 8'($urandom % 256);
            er[e] = int'($urandom % (2*lim+1)) - lim;
            ei[e] = int'($urandom % (2*lim+1)) - lim;
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int e = 0; e < D; e++) begin
            cm[e] = '0; xr[e] = '0; xi[e] = '0; er[e] = 0; ei[e] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 busy after reset", int'(busy), 0);
        check("R1 done after reset", int'(done), 0);
        compare_all("R1 reset contents");

        // R2: load and read back
        for (int e = 0; e < D; e++) begin
            er[e] = e * 9 - 70; ei[e] = 60 - e * 7;
        end
        load_est();
        compare_all("R2 load readback");

        // R3: identity correlation, zero cross term, shift 0 -> A - A = 0
        for (int e = 0; e < D; e++) cm[e] = ((e / M) == (e % M)) ? 8'sd1 : 8'sd0;
        run_sweep(0, 1'b0);
        compare_all("R3 identity residual");

        // R5: saturation at both ends with shift 0
        for (int e = 0; e < D; e++) begin
            cm[e] = '0; er[e] = (e % 2) ? 120 : -120; ei[e] = (e % 2) ? -120 : 120;
            xr[e] = (e % 2) ? 8'sd100 : -8'sd100;
            xi[e] = (e % 2) ? -8'sd100 : 8'sd100;
        end
        load_est();
        run_sweep(0, 1'b0);
        compare_all("R5 clamp");

        // R4: shift 15 with negative residual -> floor gives -1
        for (int e = 0; e < D; e++) begin
            cm[e] = 8'sd1; xr[e] = 8'sd5; xi[e] = -8'sd5; er[e] = 0; ei[e] = 0;
        end
        load_est();
        run_sweep(15, 1'b0);
        compare_all("R4 floor shift");

        // R7/R8: random sweep with meddling
        rand_mats(127);
        load_est();
        run_sweep(3, 1'b1);
        compare_all("R7 meddled sweep");

        // R3: chained random sweeps with random shifts
        for (int t = 0; t < 6; t++) begin
            rand_mats(127);
            load_est();
            run_sweep(int'($urandom % 16), 1'b0);
            run_sweep(int'($urandom % 16), 1'b0);
            compare_all("R3 chained random");
        end

        // R4: shift captured at start (bench alters shift during sweep)
        rand_mats(40);
        load_est();
        run_sweep(6, 1'b1);
        compare_all("R4 shift captured");

        if (!ended) begin
            ended = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule